// File: doc/BRIEF.md
# Graph Node Processing Element

This block is one compute tile in a mesh of tiles that run a graph algorithm in lock-step supersteps. It holds a fixed slice of a graph: the expected number of incoming messages per local node, a table of outgoing edges, and a set of shared-delivery lists. A start pulse opens a superstep. The tile then walks its edge table and injects one packet per edge, carrying the current value of the source node. At the same time it absorbs inbound packets and folds each payload into the accumulator of the addressed node with an associative combine (wrapping sum, minimum or maximum, chosen by parameter).

A unicast packet reaches one local node. A shared packet names a delivery list, and every node in that list takes the same payload in the same cycle. This lets the network carry one copy of a multicast value to the tile. Each node counts its own arrivals and flags itself ready once the count meets its expected fan-in, so its compute can begin without a global barrier. When the walk is over and every node is ready, the tile raises a done bit that feeds a chip-wide AND tree. The next start commits each accumulator as the node's new outgoing value, or loads a seed instead.

Top module: `gpe_top`

## Requirements
- R1: While rst_ni is low, and on its release, tx_valid_o, done_o and node_ready_o are all 0.
- R2: On a start_i cycle every node's count clears to 0 and its accumulator to the combine identity. Its outgoing value loads seed_i when seed_load_i is 1, and otherwise loads its accumulator from before the clear. A packet received in the start cycle is dropped.
- R3: In the cycle after start_i, the tile presents edge 0. It then presents edges 1 to cfg_edge_num_i-1 in order, one per accepted handshake. Each packet is {edge header, outgoing value of the edge's source node}. The header is {dest x, dest y, shared flag, index}.
- R4: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_pkt_o stays unchanged, so no packet is lost.
- R5: An inbound packet is split MSB to LSB as {x[COORD_W], y[COORD_W], shared[1], index[IDX_W], data[DATA_W]}. A packet matching MY_X/MY_Y with shared=0 combines data into node `index` and adds 1 to its count.
- R6: A matching packet with shared=1 combines data into every node whose bit is set in cfg_share_i[index], and adds 1 to each of their counts in the same cycle.
- R7: A packet whose x or y differs from MY_X/MY_Y changes no accumulator and no count.
- R8: The sum combine wraps modulo 2^DATA_W with identity 0. The minimum combine uses identity all-ones. The maximum combine uses identity 0. Data is compared unsigned.
- R9: node_ready_o[n] is 1 from the cycle after a start in which node n's count equals cfg_fanin_i[n], and it stays 1 until the next start. A fan-in of 0 makes the node ready right after start.
- R10: done_o is 1 exactly when a superstep is under way, the edge walk is complete and all nodes are ready. A start clears it.
- R11: Injection and reception proceed in the same cycles without stalling each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Superstep start pulse |
| seed_load_i | input | 1 | With start, load seeds as outgoing values |
| seed_i | input | NODES*DATA_W | Seed value per node |
| cfg_fanin_i | input | NODES*CNT_W | Expected inbound message count per node |
| cfg_edge_num_i | input | ECNT_W | Number of valid outgoing edges |
| cfg_edge_src_i | input | EDGES*NODE_W | Source node of each edge |
| cfg_edge_hdr_i | input | EDGES*HDR_W | Packet header of each edge |
| cfg_share_i | input | LISTS*NODES | Node mask of each shared-delivery list |
| tx_valid_o | output | 1 | Outbound packet valid |
| tx_ready_i | input | 1 | Network accepts outbound packet |
| tx_pkt_o | output | PKT_W | Outbound packet |
| rx_valid_i | input | 1 | Inbound packet valid |
| rx_pkt_i | input | PKT_W | Inbound packet |
| node_ready_o | output | NODES | Per-node all-inputs-arrived flag |
| node_acc_o | output | NODES*DATA_W | Per-node accumulator |
| done_o | output | 1 | Local barrier contribution |

## Verification
The assertions rely on legal input traffic. The configuration holds still during a superstep. No node gets more inbound messages than its stated fan-in, which keeps the ready flags monotonic. cfg_edge_num_i never exceeds EDGES. The stimulus follows these rules. Its fan-in values match the traffic exactly. Its foreign-coordinate packets are dropped by design and so do not count. The only extra packet lands in a start cycle, where it is discarded. Three instances with different combine parameters share the same stimulus, so that all three identities and folds are checked.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  typedef enum logic [1:0] {CMB_SUM, CMB_MIN, CMB_MAX} combine_e;
endpackage

// File: rtl/gpe_rx_decode.sv
module gpe_rx_decode #(
  parameter int NODES   = 4,
  parameter int LISTS   = 2,
  parameter int COORD_W = 2,
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 16,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 2,
  localparam int PKT_W  = 2*COORD_W + 1 + IDX_W + DATA_W
) (
  input  logic                         rx_valid_i,
  input  logic [PKT_W-1:0]             rx_pkt_i,
  input  logic [LISTS-1:0][NODES-1:0]  share_i,
  output logic [NODES-1:0]             hit_o,
  output logic [DATA_W-1:0]            data_o
);
  localparam int IDX_LO = DATA_W;
  localparam int SH_BIT = DATA_W + IDX_W;
  localparam int Y_LO   = SH_BIT + 1;
  localparam int X_LO   = Y_LO + COORD_W;

  logic [COORD_W-1:0] x, y;
  logic [IDX_W-1:0]   idx;
  logic               shared, mine;

  assign x      = rx_pkt_i[X_LO +: COORD_W];
  assign y      = rx_pkt_i[Y_LO +: COORD_W];
  assign idx    = rx_pkt_i[IDX_LO +: IDX_W];
  assign shared = rx_pkt_i[SH_BIT];
  assign data_o = rx_pkt_i[DATA_W-1:0];
  assign mine   = rx_valid_i && (x == COORD_W'(MY_X)) && (y == COORD_W'(MY_Y));

  always_comb begin
    hit_o = '0;
    if (mine) begin
      if (shared) begin
        for (int l = 0; l < LISTS; l++)
          if (idx == IDX_W'(l)) hit_o = share_i[l];
      end else begin
        for (int n = 0; n < NODES; n++)
          if (idx == IDX_W'(n)) hit_o[n] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpe_node_array.sv
module gpe_node_array #(
  parameter int NODES  = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4,
  parameter gpe_pkg::combine_e COMBINE = gpe_pkg::CMB_SUM
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          seed_load_i,
  input  logic [NODES-1:0][DATA_W-1:0]  seed_i,
  input  logic [NODES-1:0][CNT_W-1:0]   fanin_i,
  input  logic                          active_i,
  input  logic [NODES-1:0]              hit_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [NODES-1:0]              ready_o,
  output logic [NODES-1:0][DATA_W-1:0]  acc_o,
  output logic [NODES-1:0][DATA_W-1:0]  val_o
);
  localparam logic [DATA_W-1:0] IDENT =
    (COMBINE == gpe_pkg::CMB_MIN) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] acc_q, val_q, nxt;

    if (COMBINE == gpe_pkg::CMB_SUM) begin : g_sum
      assign nxt = acc_q + data_i;
    end else if (COMBINE == gpe_pkg::CMB_MIN) begin : g_min
      assign nxt = (data_i < acc_q) ? data_i : acc_q;
    end else begin : g_max
      assign nxt = (data_i > acc_q) ? data_i : acc_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        acc_q <= IDENT;
        val_q <= '0;
      end else if (start_i) begin
        cnt_q <= '0;
        acc_q <= IDENT;
        val_q <= seed_load_i ? seed_i[n] : acc_q;
      end else if (hit_i[n]) begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= nxt;
      end
    end

    assign ready_o[n] = active_i && (cnt_q == fanin_i[n]);
    assign acc_o[n]   = acc_q;
    assign val_o[n]   = val_q;
  end
endmodule

// File: rtl/gpe_send_walk.sv
module gpe_send_walk #(
  parameter int EDGES  = 6,
  parameter int NODES  = 4,
  parameter int DATA_W = 16,
  parameter int HDR_W  = 7,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int EIDX_W = (EDGES > 1) ? $clog2(EDGES) : 1,
  localparam int ECNT_W = $clog2(EDGES + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [ECNT_W-1:0]             edge_num_i,
  input  logic [EDGES-1:0][NODE_W-1:0]  edge_src_i,
  input  logic [EDGES-1:0][HDR_W-1:0]   edge_hdr_i,
  input  logic [NODES-1:0][DATA_W-1:0]  val_i,
  input  logic                          tx_ready_i,
  output logic                          tx_valid_o,
  output logic [HDR_W+DATA_W-1:0]       tx_pkt_o,
  output logic                          busy_o,
  output logic                          sent_all_o
);
  logic              busy_q;
  logic [ECNT_W-1:0] ptr_q;
  logic [EIDX_W-1:0] sel;
  logic              pending;

  assign pending    = (ptr_q < edge_num_i) && (ptr_q < ECNT_W'(EDGES));
  assign sel        = pending ? ptr_q[EIDX_W-1:0] : '0;
  assign tx_valid_o = busy_q && pending;
  assign tx_pkt_o   = {edge_hdr_i[sel], val_i[edge_src_i[sel]]};
  assign busy_o     = busy_q;
  assign sent_all_o = busy_q && !pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (tx_valid_o && tx_ready_i) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpe_top.sv
module gpe_top #(
  parameter int NODES   = 4,
  parameter int EDGES   = 6,
  parameter int LISTS   = 2,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4,
  parameter int COORD_W = 2,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 2,
  parameter gpe_pkg::combine_e COMBINE = gpe_pkg::CMB_SUM,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int IDX_MX = (NODES > LISTS) ? NODES : LISTS,
  localparam int IDX_W  = (IDX_MX > 1) ? $clog2(IDX_MX) : 1,
  localparam int HDR_W  = 2*COORD_W + 1 + IDX_W,
  localparam int PKT_W  = HDR_W + DATA_W,
  localparam int ECNT_W = $clog2(EDGES + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          seed_load_i,
  input  logic [NODES-1:0][DATA_W-1:0]  seed_i,
  input  logic [NODES-1:0][CNT_W-1:0]   cfg_fanin_i,
  input  logic [ECNT_W-1:0]             cfg_edge_num_i,
  input  logic [EDGES-1:0][NODE_W-1:0]  cfg_edge_src_i,
  input  logic [EDGES-1:0][HDR_W-1:0]   cfg_edge_hdr_i,
  input  logic [LISTS-1:0][NODES-1:0]   cfg_share_i,
  output logic                          tx_valid_o,
  input  logic                          tx_ready_i,
  output logic [PKT_W-1:0]              tx_pkt_o,
  input  logic                          rx_valid_i,
  input  logic [PKT_W-1:0]              rx_pkt_i,
  output logic [NODES-1:0]              node_ready_o,
  output logic [NODES-1:0][DATA_W-1:0]  node_acc_o,
  output logic                          done_o
);
  logic [NODES-1:0]             hit_mask;
  logic [DATA_W-1:0]            rx_data;
  logic [NODES-1:0][DATA_W-1:0] node_val;
  logic                         busy, sent_all;

  gpe_rx_decode #(
    .NODES(NODES), .LISTS(LISTS), .COORD_W(COORD_W), .IDX_W(IDX_W),
    .DATA_W(DATA_W), .MY_X(MY_X), .MY_Y(MY_Y)
  ) u_dec (
    .rx_valid_i (rx_valid_i && !start_i),
    .rx_pkt_i   (rx_pkt_i),
    .share_i    (cfg_share_i),
    .hit_o      (hit_mask),
    .data_o     (rx_data)
  );

  gpe_node_array #(
    .NODES(NODES), .DATA_W(DATA_W), .CNT_W(CNT_W), .COMBINE(COMBINE)
  ) u_nodes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .seed_load_i (seed_load_i),
    .seed_i      (seed_i),
    .fanin_i     (cfg_fanin_i),
    .active_i    (busy),
    .hit_i       (hit_mask),
    .data_i      (rx_data),
    .ready_o     (node_ready_o),
    .acc_o       (node_acc_o),
    .val_o       (node_val)
  );

  gpe_send_walk #(
    .EDGES(EDGES), .NODES(NODES), .DATA_W(DATA_W), .HDR_W(HDR_W)
  ) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .edge_num_i (cfg_edge_num_i),
    .edge_src_i (cfg_edge_src_i),
    .edge_hdr_i (cfg_edge_hdr_i),
    .val_i      (node_val),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_pkt_o   (tx_pkt_o),
    .busy_o     (busy),
    .sent_all_o (sent_all)
  );

  assign done_o = busy && sent_all && (&node_ready_o);
endmodule

// File: rtl/gpe_top_chk.sv
module gpe_top_chk #(
  parameter int NODES   = 4,
  parameter int PKT_W   = 23,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 2,
  parameter int COORD_W = 2,
  parameter int ECNT_W  = 3,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rx_valid_i,
  input logic [PKT_W-1:0]  rx_pkt_i,
  input logic              tx_ready_i,
  input logic              tx_valid_o,
  input logic [PKT_W-1:0]  tx_pkt_o,
  input logic [NODES-1:0]  node_ready_o,
  input logic              done_o,
  input logic [NODES-1:0]  hit_mask,
  input logic [ECNT_W-1:0] cfg_edge_num_i
);
  localparam int SH_BIT = DATA_W + IDX_W;
  localparam int Y_LO   = SH_BIT + 1;
  localparam int X_LO   = Y_LO + COORD_W;

  logic foreign;
  assign foreign = (rx_pkt_i[X_LO +: COORD_W] != COORD_W'(MY_X)) ||
                   (rx_pkt_i[Y_LO +: COORD_W] != COORD_W'(MY_Y));

  p_tx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !start_i) |=> (tx_valid_o && $stable(tx_pkt_o)));

  p_done_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((&node_ready_o) && !tx_valid_o));

  p_start_walk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cfg_edge_num_i != '0) |=> (tx_valid_o && !done_o));

  p_ready_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ((node_ready_o & $past(node_ready_o)) == $past(node_ready_o)));

  p_unicast_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_pkt_i[SH_BIT]) |-> $onehot0(hit_mask));

  p_foreign_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && foreign) |-> (hit_mask == '0));

  p_start_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (hit_mask == '0));
endmodule

bind gpe_top gpe_top_chk #(
  .NODES(NODES), .PKT_W(PKT_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
  .COORD_W(COORD_W), .ECNT_W(ECNT_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .rx_valid_i     (rx_valid_i),
  .rx_pkt_i       (rx_pkt_i),
  .tx_ready_i     (tx_ready_i),
  .tx_valid_o     (tx_valid_o),
  .tx_pkt_o       (tx_pkt_o),
  .node_ready_o   (node_ready_o),
  .done_o         (done_o),
  .hit_mask       (hit_mask),
  .cfg_edge_num_i (cfg_edge_num_i)
);

// File: tb/gpe_top_bench.sv
module gpe_top_bench;
  localparam int NODES = 4, EDGES = 6, LISTS = 2, DATA_W = 16, CNT_W = 4;
  localparam int PKT_W = 23, HDR_W = 7;

  typedef struct packed {
    logic [PKT_W-1:0]             pkt;
    logic [NODES-1:0][DATA_W-1:0] acc;
    logic [NODES-1:0]             rdy;
  } vec_t;

  // pkt = {x,y,shared,idx,data}; this tile sits at x=1,y=2
  localparam vec_t VEC [5] = '{
    '{ {2'd1,2'd2,1'b0,2'd0,16'd5},   {16'd0,16'd0,16'd0,16'd5},  4'b1000 },
    '{ {2'd0,2'd2,1'b0,2'd0,16'd100}, {16'd0,16'd0,16'd0,16'd5},  4'b1000 },
    '{ {2'd1,2'd2,1'b1,2'd0,16'd7},   {16'd0,16'd7,16'd7,16'd5},  4'b1100 },
    '{ {2'd1,2'd2,1'b1,2'd1,16'd3},   {16'd0,16'd7,16'd10,16'd8}, 4'b1111 },
    '{ {2'd1,2'd0,1'b0,2'd1,16'd9},   {16'd0,16'd7,16'd10,16'd8}, 4'b1111 }
  };
  localparam logic [HDR_W-1:0] EHDR [3] = '{
    {2'd3,2'd0,1'b0,2'd1}, {2'd1,2'd1,1'b1,2'd0}, {2'd0,2'd3,1'b0,2'd3} };
  localparam int ESRC [3] = '{0, 2, 1};

  logic clk_i = 0, rst_ni = 0;
  logic start_i = 0, seed_load_i = 0, tx_ready_i = 0, rx_valid_i = 0;
  logic [PKT_W-1:0] rx_pkt_i = '0;
  logic [NODES-1:0][DATA_W-1:0] seed_i;
  logic [NODES-1:0][CNT_W-1:0]  cfg_fanin_i;
  logic [2:0]                   cfg_edge_num_i;
  logic [EDGES-1:0][1:0]        cfg_edge_src_i;
  logic [EDGES-1:0][HDR_W-1:0]  cfg_edge_hdr_i;
  logic [LISTS-1:0][NODES-1:0]  cfg_share_i;

  logic tx_valid_o, done_o;
  logic [PKT_W-1:0] tx_pkt_o;
  logic [NODES-1:0] node_ready_o;
  logic [NODES-1:0][DATA_W-1:0] node_acc_o, acc_min, acc_max;
  logic v_min, v_max, d_min, d_max;
  logic [PKT_W-1:0] p_min, p_max;
  logic [NODES-1:0] r_min, r_max;

  int checks = 0, errors = 0;
  logic [NODES-1:0][DATA_W-1:0] step_val;

  always #5 clk_i = ~clk_i;

  gpe_top u_gpe_top (
    .clk_i, .rst_ni, .start_i, .seed_load_i, .seed_i, .cfg_fanin_i,
    .cfg_edge_num_i, .cfg_edge_src_i, .cfg_edge_hdr_i, .cfg_share_i,
    .tx_valid_o, .tx_ready_i, .tx_pkt_o, .rx_valid_i, .rx_pkt_i,
    .node_ready_o, .node_acc_o, .done_o);

  gpe_top #(.COMBINE(gpe_pkg::CMB_MIN)) u_gpe_top_min (
    .clk_i, .rst_ni, .start_i, .seed_load_i, .seed_i, .cfg_fanin_i,
    .cfg_edge_num_i, .cfg_edge_src_i, .cfg_edge_hdr_i, .cfg_share_i,
    .tx_valid_o(v_min), .tx_ready_i, .tx_pkt_o(p_min), .rx_valid_i, .rx_pkt_i,
    .node_ready_o(r_min), .node_acc_o(acc_min), .done_o(d_min));

  gpe_top #(.COMBINE(gpe_pkg::CMB_MAX)) u_gpe_top_max (
    .clk_i, .rst_ni, .start_i, .seed_load_i, .seed_i, .cfg_fanin_i,
    .cfg_edge_num_i, .cfg_edge_src_i, .cfg_edge_hdr_i, .cfg_share_i,
    .tx_valid_o(v_max), .tx_ready_i, .tx_pkt_o(p_max), .rx_valid_i, .rx_pkt_i,
    .node_ready_o(r_max), .node_acc_o(acc_max), .done_o(d_max));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_tx(string req, int e);
    chk({req, " tx_valid"}, 64'(tx_valid_o), 64'd1);
    chk({req, " tx_pkt"}, 64'(tx_pkt_o), 64'({EHDR[e], step_val[ESRC[e]]}));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_i         = {16'h0044, 16'h0033, 16'h0022, 16'h0011};
    cfg_fanin_i    = {4'd0, 4'd1, 4'd2, 4'd2};
    cfg_edge_num_i = 3'd3;
    cfg_edge_src_i = '0;
    cfg_edge_hdr_i = '0;
    for (int e = 0; e < 3; e++) begin
      cfg_edge_src_i[e] = 2'(ESRC[e]);
      cfg_edge_hdr_i[e] = EHDR[e];
    end
    cfg_share_i = {4'b0011, 4'b0110};

    repeat (3) @(negedge clk_i);
    chk("R1 tx_valid in reset", 64'(tx_valid_o), 0);
    chk("R1 done in reset", 64'(done_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 ready after reset", 64'(node_ready_o), 0);

    // step 1: seeded, first edge stalled
    start_i = 1; seed_load_i = 1;
    @(negedge clk_i);
    start_i = 0; seed_load_i = 0;
    step_val = seed_i;
    chk_tx("R3 first edge", 0);
    chk("R9 zero fan-in ready", 64'(node_ready_o), 64'(4'b1000));
    chk("R10 done low", 64'(done_o), 0);
    @(negedge clk_i);
    chk_tx("R4 stalled hold", 0);

    // R11 send and receive together; R5 R6 R7 via table
    for (int i = 0; i < 5; i++) begin
      if (i < 3) chk_tx("R3 R11 walk", i);
      else chk("R3 walk ended", 64'(tx_valid_o), 0);
      tx_ready_i = 1;
      rx_valid_i = 1; rx_pkt_i = VEC[i].pkt;
      @(negedge clk_i);
      rx_valid_i = 0;
      chk("R5 R6 R7 acc", 64'(node_acc_o), 64'(VEC[i].acc));
      chk("R9 ready", 64'(node_ready_o), 64'(VEC[i].rdy));
    end
    chk("R10 done", 64'(done_o), 1);
    chk("R8 min fold", 64'(acc_min), {16'hFFFF, 16'd7, 16'd3, 16'd3});
    chk("R8 max fold", 64'(acc_max), {16'd0, 16'd7, 16'd7, 16'd5});

    // step 2: commit accumulators, packet in start cycle dropped
    tx_ready_i = 0;
    start_i = 1;
    rx_valid_i = 1; rx_pkt_i = {2'd1, 2'd2, 1'b0, 2'd2, 16'd50};
    @(negedge clk_i);
    start_i = 0; rx_valid_i = 0;
    step_val = {16'd0, 16'd7, 16'd10, 16'd8};
    chk("R2 acc cleared", 64'(node_acc_o), 0);
    chk("R2 min identity", 64'(acc_min[3]), 64'(16'hFFFF));
    chk("R2 ready cleared", 64'(node_ready_o), 64'(4'b1000));
    chk("R10 done cleared", 64'(done_o), 0);
    chk_tx("R2 committed value", 0);

    tx_ready_i = 1;
    rx_valid_i = 1; rx_pkt_i = {2'd1, 2'd2, 1'b0, 2'd0, 16'hFFF0};
    @(negedge clk_i);
    chk_tx("R2 R11 walk", 1);
    rx_pkt_i = {2'd1, 2'd2, 1'b0, 2'd0, 16'h0020};
    @(negedge clk_i);
    rx_valid_i = 0;
    chk_tx("R2 R11 walk", 2);
    chk("R8 sum wrap", 64'(node_acc_o[0]), 64'(16'h0010));
    chk("R8 min", 64'(acc_min[0]), 64'(16'h0020));
    chk("R8 max", 64'(acc_max[0]), 64'(16'hFFF0));
    chk("R9 node0 ready", 64'(node_ready_o), 64'(4'b1001));
    chk("R10 done waits", 64'(done_o), 0);

    rst_ni = 0;
    @(negedge clk_i);
    chk("R1 reset tx", 64'(tx_valid_o), 0);
    chk("R1 reset ready", 64'(node_ready_o), 0);
    chk("R1 reset done", 64'(done_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule